// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of 32 already-synchronized GPIO input pins and turns configured pin activity into a single interrupt request. Each pin is set up on its own either to react to a level (high or low) or to an edge (rising, falling, or both directions). Every qualifying event lands in a sticky status bit. Software clears a status bit by writing a 1 to it.

A mask decides which status bits may reach the interrupt line. Software never writes the mask directly. One write-only port clears mask bits (unmasking pins) and another sets them (masking pins). The current mask can be read back. Detection and latching keep running while a pin is masked. An event that arrives during that time therefore raises the interrupt as soon as the pin is unmasked. Software is expected to clear the status bit before it unmasks a pin.

The register bus is a plain single-cycle write port with a combinational read path. The word index is decoded from a 3-bit address.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held, and right after it, every mask bit reads 1, status reads 0, and the mode, polarity and both-edge registers read 0.
- R2: Word index 0 is the mode register, one bit per pin. A 1 selects edge detection and a 0 selects level detection.
- R3: Word index 1 is the polarity register. A 1 means rising edge or high level, and a 0 means falling edge or low level.
- R4: Word index 2 is the both-edge register. When its bit is 1 on an edge-mode pin, that pin reacts to a rise and to a fall, whatever its polarity bit holds.
- R5: The both-edge bit has no effect on a level-mode pin.
- R6: Word index 3 reads the sticky status. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged. An event sets its bit at the next clock edge.
- R7: Writing to word index 4 clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R8: Writing to word index 5 sets each mask bit whose data bit is 1. Word index 6 reads the mask. Words 4, 5 and 7 read as 0.
- R9: Events are still detected and latched while a pin is masked. An event held from that time drives the interrupt once the pin is unmasked.
- R10: The interrupt output is high exactly when some status bit is 1 and its mask bit is 0.
- R11: A level-mode pin that stays at its active level sets its status bit again on every cycle, so a clear does not last.
- R12: When a clear and a new event hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 32 | Synchronized GPIO input levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word index |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach is a clear and a fresh edge landing on the same status bit in one cycle. The bench reaches it with a directed step that raises an edge-mode pin in the same cycle as the write that clears that pin's status bit. It also builds up a stale event behind the mask and then unmasks the pin. Random stretches of pin toggles, mixed with configuration, clear and mask writes, run against a cycle model of the requirements. These stretches also produce same-cycle collisions between events and bus writes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MODE    = 3'd0,
        SEL_POL     = 3'd1,
        SEL_BOTH    = 3'd2,
        SEL_STAT    = 3'd3,
        SEL_UNMASK  = 3'd4,
        SEL_MASKSET = 3'd5,
        SEL_MASK    = 3'd6,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic edge_mode;
        logic rise_high;
        logic both;
    } pin_cfg_t;

    // Single-pin event decision from the configuration, the present level and the previous level.
    function automatic logic pin_event(pin_cfg_t c, logic now, logic prev);
        logic rise, fall;
        rise = now & ~prev;
        fall = ~now & prev;
        if (c.edge_mode) begin
            if (c.both) return rise | fall;
            return c.rise_high ? rise : fall;
        end
        return c.rise_high ? now : ~now;
    endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int W  = PIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  mode_q,
    output logic [W-1:0]  pol_q,
    output logic [W-1:0]  both_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  stat_clr
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
            mask_q <= '1;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE:    mode_q <= wr_data;
                SEL_POL:     pol_q  <= wr_data;
                SEL_BOTH:    both_q <= wr_data;
                SEL_UNMASK:  mask_q <= mask_q & ~wr_data;
                SEL_MASKSET: mask_q <= mask_q | wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_clr = '0;
        if (wr_en && sel == SEL_STAT) stat_clr = wr_data;
    end

    // R7
    unmask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_UNMASK) |=> ((mask_q & $past(wr_data)) == '0));

    // R8
    maskset_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_MASKSET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = PIN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] mode_q,
    input  logic [W-1:0] pol_q,
    input  logic [W-1:0] both_q,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pins;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_cfg_t cfg_w;
        assign cfg_w = '{edge_mode: mode_q[i], rise_high: pol_q[i], both: both_q[i]};
        assign evt[i] = pin_event(cfg_w, pins[i], prev_q[i]);
    end

    // R4
    both_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_q & both_q & (pins ^ prev_q)) & ~evt) == '0);

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int W = PIN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] stat_q,
    output logic         irq
);

    logic [W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | evt;
    end

    assign live = stat_q & ~mask_q;
    assign irq  = |live;

    // R12
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & $past(clr & ~evt)) == '0));

    // R6
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int W  = PIN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  pins,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          irq
);

    logic [W-1:0] mode_q, pol_q, both_q, mask_q, stat_clr, evt, stat_q;

    gpio_irq_cfg #(.W(W), .AW(AW)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mode_q(mode_q), .pol_q(pol_q), .both_q(both_q), .mask_q(mask_q),
        .stat_clr(stat_clr)
    );

    gpio_irq_detect #(.W(W)) u_detect (
        .clk(clk), .rst(rst), .pins(pins), .mode_q(mode_q), .pol_q(pol_q),
        .both_q(both_q), .evt(evt)
    );

    gpio_irq_status #(.W(W)) u_status (
        .clk(clk), .rst(rst), .evt(evt), .clr(stat_clr), .mask_q(mask_q),
        .stat_q(stat_q), .irq(irq)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_MODE: rd_data = mode_q;
            SEL_POL:  rd_data = pol_q;
            SEL_BOTH: rd_data = both_q;
            SEL_STAT: rd_data = stat_q;
            SEL_MASK: rd_data = mask_q;
            default:  rd_data = '0;
        endcase
    end

    // R10
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq);

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst(rst), .pins(pins), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Reference state built from the requirements
    logic [31:0] m_mode, m_pol, m_both, m_mask, m_stat, m_prev;

    function automatic logic [31:0] ref_evt(logic [31:0] p, logic [31:0] q);
        logic [31:0] e;
        for (int i = 0; i < 32; i++) begin
            if (m_mode[i]) begin
                if (m_both[i])     e[i] = p[i] ^ q[i];
                else if (m_pol[i]) e[i] = p[i] & ~q[i];
                else               e[i] = ~p[i] & q[i];
            end else begin
                e[i] = m_pol[i] ? p[i] : ~p[i];
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] ref_read(logic [2:0] a);
        case (a)
            3'd0: return m_mode;
            3'd1: return m_pol;
            3'd2: return m_both;
            3'd3: return m_stat;
            3'd6: return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= '0; m_pol <= '0; m_both <= '0;
            m_mask <= '1; m_stat <= '0; m_prev <= '0;
        end else begin
            logic [31:0] clr;
            clr = (wr_en && addr == 3'd3) ? wr_data : 32'h0;
            m_stat <= (m_stat & ~clr) | ref_evt(pins, m_prev);
            m_prev <= pins;
            if (wr_en) begin
                case (addr)
                    3'd0: m_mode <= wr_data;
                    3'd1: m_pol  <= wr_data;
                    3'd2: m_both <= wr_data;
                    3'd4: m_mask <= m_mask & ~wr_data;
                    3'd5: m_mask <= m_mask | wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare read data and irq against the model
    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic [31:0] p, input string tag);
        @(negedge clk);
        wr_en = w; addr = a; wr_data = d; pins = p;
        #1;
        chk(tag, rd_data, ref_read(a));
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b0, a, 32'h0, pins, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'd4711));
        // R1: values while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk); addr = 3'd6; #1; chk("R1 mask", rd_data, 32'hFFFF_FFFF);
        addr = 3'd3; #1; chk("R1 status", rd_data, 32'h0);
        addr = 3'd0; #1; chk("R1 mode", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rst = 1'b0;
        rd(3'd1, "R1 pol");
        rd(3'd2, "R1 both");

        // Default level-low config latches every low pin; move to high level and clear
        step(1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0, "R3");
        step(1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0, "R6");
        rd(3'd3, "R6");
        chk("R6 cleared", rd_data, 32'h0);

        // R2/R3: pin0 rising edge
        step(1'b1, 3'd0, 32'h1, 32'h0, "R2");
        step(1'b0, 3'd3, 32'h0, 32'h1, "R2");
        rd(3'd3, "R2");
        chk("R2 rise latched", rd_data, 32'h1);
        step(1'b1, 3'd3, 32'h0, 32'h1, "R6 zero write");
        rd(3'd3, "R6");
        chk("R6 zero write keeps", rd_data, 32'h1);
        step(1'b1, 3'd3, 32'h1, 32'h1, "R6 clear");
        rd(3'd3, "R6");
        chk("R6 edge not retriggered", rd_data, 32'h0);

        // R3: falling edge on pin0
        step(1'b1, 3'd1, 32'hFFFF_FFFE, 32'h1, "R3");
        step(1'b0, 3'd3, 32'h0, 32'h0, "R3");
        rd(3'd3, "R3");
        chk("R3 fall latched", rd_data, 32'h1);
        step(1'b1, 3'd3, 32'h1, 32'h0, "R3");

        // R4: both edges, polarity irrelevant
        step(1'b1, 3'd2, 32'h3, 32'h0, "R4");
        step(1'b0, 3'd3, 32'h0, 32'h1, "R4");
        rd(3'd3, "R4");
        chk("R4 rise", rd_data, 32'h1);
        step(1'b1, 3'd3, 32'h1, 32'h0, "R4");
        rd(3'd3, "R4");
        chk("R4 fall", rd_data, 32'h1);
        step(1'b1, 3'd3, 32'h1, 32'h0, "R4");

        // R5/R11: pin1 level-high with both-edge set
        step(1'b0, 3'd3, 32'h0, 32'h2, "R5");
        step(1'b0, 3'd3, 32'h0, 32'h0, "R5");
        step(1'b1, 3'd3, 32'h2, 32'h0, "R5");
        rd(3'd3, "R5");
        chk("R5 fall ignored on level pin", rd_data, 32'h0);
        step(1'b0, 3'd3, 32'h0, 32'h2, "R11");
        step(1'b1, 3'd3, 32'h2, 32'h2, "R11");
        rd(3'd3, "R11");
        chk("R11 level persists", rd_data, 32'h2);

        // R7/R8: mask through unmask and mask-set ports
        step(1'b1, 3'd4, 32'h3, 32'h2, "R7");
        rd(3'd6, "R7");
        chk("R7 unmask", rd_data, 32'hFFFF_FFFC);
        chk("R10 irq live", {31'b0, irq}, 32'h1);
        step(1'b1, 3'd5, 32'h2, 32'h2, "R8");
        rd(3'd6, "R8");
        chk("R8 maskset", rd_data, 32'hFFFF_FFFE);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        rd(3'd4, "R8 unmask reads zero");
        rd(3'd5, "R8 maskset reads zero");

        // R9: pin1 masked and active; unmask shows stale event
        step(1'b0, 3'd6, 32'h0, 32'h0, "R9");
        step(1'b1, 3'd4, 32'h2, 32'h0, "R9");
        rd(3'd3, "R9");
        chk("R9 irq on unmask", {31'b0, irq}, 32'h1);

        // R12: clear and new rising edge on pin0 together
        step(1'b1, 3'd2, 32'h0, 32'h0, "R12");
        step(1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0, "R12");
        step(1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0, "R12");
        step(1'b1, 3'd3, 32'h1, 32'h1, "R12");
        rd(3'd3, "R12");
        chk("R12 event wins", rd_data & 32'h1, 32'h1);

        // Random mix against the model
        p = 32'h0;
        for (int n = 0; n < 600; n++) begin
            logic w;
            logic [2:0] a;
            logic [31:0] d;
            p = p ^ ($urandom & $urandom & $urandom);
            w = ($urandom % 3) == 0;
            a = 3'($urandom % 8);
            d = $urandom;
            step(w, a, d, p, "R10 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule